// File: doc/BRIEF.md
# ITU-R 656 Video Receiver

The receiver takes a byte-serial digital video stream in the ITU-R 656 style, one word per accepted cycle of its port clock. It finds the embedded timing reference codes, decodes the field, vertical-blanking and horizontal-blanking flags they carry, and forwards the words of one chosen region of the field. The region is active picture only, vertical-blanking lines only, or everything. Each forwarded word comes out with the flags in effect for it and with a start-of-line and a start-of-field marker.

A timing reference is four words: a word whose key byte is all ones, two words whose key bytes are zero, and a status word. The status word's key byte holds a set marker bit, then the F, V and H bits, then four protection bits. The protection bits are not checked. Words pass through a four-word delay line, so the three preamble words can be tagged as reference words once the status word confirms them. A word leaves when four more words have been accepted behind it. Nothing moves while the input is idle.

Top module: `vid656_rx`

## Requirements
- R1: While reset is held, and until the first word is forwarded, `vid_valid`, `vid_sol` and `vid_sof` are 0 and the flag outputs read F=0, V=0, H=1. The decoder starts in the same flag state.
- R2: A status word is recognised when the three words accepted before it have key bytes 0xFF, 0x00, 0x00 (oldest first) and its own key bit 7 is 1. Its key bits 6, 5 and 4 give F, V and H. A candidate whose key bit 7 is 0 is treated as ordinary video.
- R3: The key byte is `pix_data[7:0]` when `cfg_wide`=0, and then `pix_data[9:8]` plays no part in matching. It is `pix_data[9:2]` when `cfg_wide`=1. Forwarded data keeps all 10 bits unchanged.
- R4: The word accepted with the k-th accepted input is presented on the outputs in the clock cycle after the (k+4)-th input is accepted. `vid_valid` is high for that one cycle.
- R5: `cfg_mode` selects the region: 0 is active video, 1 is vertical blanking, and 2 or 3 is the entire field.
- R6: In active-video mode, only non-reference words with V=0 and H=0 are forwarded. These are the words after a start-of-active-video code (H=0) and before the next end-of-active-video code (H=1).
- R7: In vertical-blanking mode, only non-reference words with V=1 are forwarded.
- R8: In entire-field mode, every accepted word is forwarded, including all four words of each timing reference.
- R9: The flags output with a word are those in effect for it. A status word carries its own new flags. Its three preamble words carry the flags from before the status word.
- R10: `vid_sof` is 1 with the first forwarded word whose F differs from the F of the word that left the delay line before it. If that word is not forwarded, the marker goes with the next forwarded word.
- R11: `vid_sol` is 1 with the first forwarded word after a start-of-active-video status word (H=0). The status word itself never carries `vid_sol`.
- R12: When `pix_valid` is 0, no word advances and `vid_valid` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Input word accepted this cycle |
| pix_data | input | 10 | Input video word |
| cfg_wide | input | 1 | 1: 10-bit words, key on bits 9:2; 0: key on bits 7:0 |
| cfg_mode | input | 2 | Region select (0 active, 1 vertical blanking, 2/3 entire field) |
| vid_valid | output | 1 | Forwarded word present |
| vid_data | output | 10 | Forwarded word |
| vid_sol | output | 1 | Start-of-line marker |
| vid_sof | output | 1 | Start-of-field marker |
| vid_field | output | 1 | F flag for the forwarded word |
| vid_vblank | output | 1 | V flag for the forwarded word |
| vid_hblank | output | 1 | H flag for the forwarded word |

## Verification
Every result is due one clock after the fourth input accepted behind its word, so latency is counted in accepted inputs and not in clock cycles. The bench gives each driven word its acceptance index. The monitor counts acceptances independently, and each forwarded word must appear when that count equals its index plus five. Idle gaps inserted into one run check that stalled cycles neither move the data nor produce output. Words still inside the delay line at the end of a run are removed from the expected queue before the check that the queue is empty.

// File: rtl/vid656_pkg.sv
package vid656_pkg;

  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } vflags_t;

  typedef enum logic [1:0] {
    MODE_ACTIVE = 2'd0,
    MODE_VBLANK = 2'd1,
    MODE_FIELD  = 2'd2,
    MODE_FIELD2 = 2'd3
  } vmode_e;

  localparam vflags_t FLAGS_RESET = '{f: 1'b0, v: 1'b0, h: 1'b1};

endpackage

// File: rtl/vid656_trs_detect.sv
module vid656_trs_detect
  import vid656_pkg::*;
#(
  parameter int DW = 10,
  parameter int KW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pix_valid,
  input  logic [DW-1:0]       pix_data,
  input  logic                cfg_wide,
  input  logic [2:0][DW-1:0]  hist_d,
  input  logic [2:0]          hist_vld,
  output logic                hit,
  output logic                sav,
  output vflags_t             word_flags
);

  localparam logic [KW-1:0] KEY_ONES  = {KW{1'b1}};
  localparam logic [KW-1:0] KEY_ZEROS = '0;

  function automatic logic [KW-1:0] key_of(input logic [DW-1:0] d, input logic wide);
    return wide ? d[DW-1 -: KW] : d[KW-1:0];
  endfunction

  logic [KW-1:0] key_in;
  vflags_t       decoded;
  vflags_t       flags_q, flags_n;

  always_comb begin
    key_in    = key_of(pix_data, cfg_wide);
    decoded.f = key_in[KW-2];
    decoded.v = key_in[KW-3];
    decoded.h = key_in[KW-4];
    hit = pix_valid && (&hist_vld)
          && (key_of(hist_d[2], cfg_wide) == KEY_ONES)
          && (key_of(hist_d[1], cfg_wide) == KEY_ZEROS)
          && (key_of(hist_d[0], cfg_wide) == KEY_ZEROS)
          && key_in[KW-1];
    sav        = hit && !decoded.h;
    word_flags = hit ? decoded : flags_q;
    flags_n    = hit ? decoded : flags_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= FLAGS_RESET;
    else        flags_q <= flags_n;
  end

  // R9: decoded flags only change on a recognised status word
  p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(flags_q));

  // R2: a recognised status word needs an accepted input word
  p_hit_on_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> !hit);

endmodule

// File: rtl/vid656_delay_line.sv
module vid656_delay_line
  import vid656_pkg::*;
#(
  parameter int DW    = 10,
  parameter int DEPTH = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      adv,
  input  logic [DW-1:0]             in_d,
  input  vflags_t                   in_fl,
  input  logic                      in_sav,
  input  logic                      hit,
  output logic [DEPTH-2:0][DW-1:0]  hist_d,
  output logic [DEPTH-2:0]          hist_vld,
  output logic [DW-1:0]             tail_d,
  output vflags_t                   tail_fl,
  output logic                      tail_trs,
  output logic                      tail_sav,
  output logic                      tail_vld
);

  logic    [DEPTH-1:0][DW-1:0] d_q, d_n;
  vflags_t [DEPTH-1:0]         fl_q, fl_n;
  logic    [DEPTH-1:0]         trs_q, trs_n;
  logic    [DEPTH-1:0]         sav_q, sav_n;
  logic    [DEPTH-1:0]         vld_q, vld_n;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign d_n[i]   = adv ? in_d   : d_q[i];
      assign fl_n[i]  = adv ? in_fl  : fl_q[i];
      assign trs_n[i] = adv ? hit    : trs_q[i];
      assign sav_n[i] = adv ? in_sav : sav_q[i];
      assign vld_n[i] = adv ? 1'b1   : vld_q[i];
    end else begin : g_body
      // a status word entering tags the preamble words already held
      assign d_n[i]   = adv ? d_q[i-1]              : d_q[i];
      assign fl_n[i]  = adv ? fl_q[i-1]             : fl_q[i];
      assign trs_n[i] = adv ? (trs_q[i-1] | hit)    : trs_q[i];
      assign sav_n[i] = adv ? sav_q[i-1]            : sav_q[i];
      assign vld_n[i] = adv ? vld_q[i-1]            : vld_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q   <= '0;
      fl_q  <= {DEPTH{FLAGS_RESET}};
      trs_q <= '0;
      sav_q <= '0;
      vld_q <= '0;
    end else begin
      d_q   <= d_n;
      fl_q  <= fl_n;
      trs_q <= trs_n;
      sav_q <= sav_n;
      vld_q <= vld_n;
    end
  end

  assign hist_d   = d_q[DEPTH-2:0];
  assign hist_vld = vld_q[DEPTH-2:0];
  assign tail_d   = d_q[DEPTH-1];
  assign tail_fl  = fl_q[DEPTH-1];
  assign tail_trs = trs_q[DEPTH-1];
  assign tail_sav = sav_q[DEPTH-1];
  assign tail_vld = vld_q[DEPTH-1];

  // R12: contents hold while the input is idle
  p_hold_when_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(d_q) && $stable(vld_q));

endmodule

// File: rtl/vid656_region_gate.sv
module vid656_region_gate
  import vid656_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  vmode_e        mode,
  input  logic [DW-1:0] tail_d,
  input  vflags_t       tail_fl,
  input  logic          tail_trs,
  input  logic          tail_sav,
  input  logic          tail_vld,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output vflags_t       out_fl,
  output logic          out_sol,
  output logic          out_sof
);

  logic          in_region, step, fwd, f_chg;
  logic          pend_sol_q, pend_sol_n;
  logic          pend_sof_q, pend_sof_n;
  logic          last_f_q, last_f_n;
  logic          valid_n, sol_n, sof_n;
  logic [DW-1:0] data_n;
  vflags_t       fl_n;

  always_comb begin
    unique case (mode)
      MODE_ACTIVE: in_region = !tail_trs && !tail_fl.v && !tail_fl.h;
      MODE_VBLANK: in_region = !tail_trs && tail_fl.v;
      default:     in_region = 1'b1;
    endcase
    step  = adv && tail_vld;
    fwd   = step && in_region;
    f_chg = step && (tail_fl.f != last_f_q);

    valid_n    = fwd;
    data_n     = fwd ? tail_d  : out_data;
    fl_n       = fwd ? tail_fl : out_fl;
    sol_n      = fwd && pend_sol_q;
    sof_n      = fwd && (pend_sof_q || f_chg);
    last_f_n   = step ? tail_fl.f : last_f_q;
    pend_sof_n = fwd ? 1'b0 : (pend_sof_q || f_chg);
    if (step && tail_sav) pend_sol_n = 1'b1;
    else if (fwd)         pend_sol_n = 1'b0;
    else                  pend_sol_n = pend_sol_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_fl     <= FLAGS_RESET;
      out_sol    <= 1'b0;
      out_sof    <= 1'b0;
      pend_sol_q <= 1'b0;
      pend_sof_q <= 1'b0;
      last_f_q   <= 1'b0;
    end else begin
      out_valid  <= valid_n;
      out_data   <= data_n;
      out_fl     <= fl_n;
      out_sol    <= sol_n;
      out_sof    <= sof_n;
      pend_sol_q <= pend_sol_n;
      pend_sof_q <= pend_sof_n;
      last_f_q   <= last_f_n;
    end
  end

  p_active_region_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(mode) == MODE_ACTIVE) |-> (!out_fl.v && !out_fl.h));

  p_vblank_region_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(mode) == MODE_VBLANK) |-> out_fl.v);

  p_sof_qualified_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);

  p_sol_qualified_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_sol |-> out_valid);

  p_no_output_stalled_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> !out_valid);

endmodule

// File: rtl/vid656_rx.sv
module vid656_rx
  import vid656_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_valid,
  input  logic [DW-1:0] pix_data,
  input  logic          cfg_wide,
  input  logic [1:0]    cfg_mode,
  output logic          vid_valid,
  output logic [DW-1:0] vid_data,
  output logic          vid_sol,
  output logic          vid_sof,
  output logic          vid_field,
  output logic          vid_vblank,
  output logic          vid_hblank
);

  localparam int KEY_W   = 8;
  localparam int PRE_LEN = 4;

  logic                       hit, sav;
  vflags_t                    word_fl, tail_fl, out_fl;
  logic [PRE_LEN-2:0][DW-1:0] hist_d;
  logic [PRE_LEN-2:0]         hist_vld;
  logic [DW-1:0]              tail_d;
  logic                       tail_trs, tail_sav, tail_vld;
  vmode_e                     mode;

  assign mode = vmode_e'(cfg_mode);

  vid656_trs_detect #(.DW(DW), .KW(KEY_W)) u_detect (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_valid  (pix_valid),
    .pix_data   (pix_data),
    .cfg_wide   (cfg_wide),
    .hist_d     (hist_d),
    .hist_vld   (hist_vld),
    .hit        (hit),
    .sav        (sav),
    .word_flags (word_fl)
  );

  vid656_delay_line #(.DW(DW), .DEPTH(PRE_LEN)) u_delay (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (pix_valid),
    .in_d     (pix_data),
    .in_fl    (word_fl),
    .in_sav   (sav),
    .hit      (hit),
    .hist_d   (hist_d),
    .hist_vld (hist_vld),
    .tail_d   (tail_d),
    .tail_fl  (tail_fl),
    .tail_trs (tail_trs),
    .tail_sav (tail_sav),
    .tail_vld (tail_vld)
  );

  vid656_region_gate #(.DW(DW)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (pix_valid),
    .mode      (mode),
    .tail_d    (tail_d),
    .tail_fl   (tail_fl),
    .tail_trs  (tail_trs),
    .tail_sav  (tail_sav),
    .tail_vld  (tail_vld),
    .out_valid (vid_valid),
    .out_data  (vid_data),
    .out_fl    (out_fl),
    .out_sol   (vid_sol),
    .out_sof   (vid_sof)
  );

  assign vid_field  = out_fl.f;
  assign vid_vblank = out_fl.v;
  assign vid_hblank = out_fl.h;

endmodule

// File: tb/vid656_rx_tb.sv
module vid656_rx_tb;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    int         idx;
    logic [9:0] d;
    logic       f, v, h, sol, sof;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_valid = 1'b0;
  logic [9:0] pix_data = '0;
  logic       cfg_wide = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic       vid_valid, vid_sol, vid_sof, vid_field, vid_vblank, vid_hblank;
  logic [9:0] vid_data;

  int    checks = 0;
  int    fails  = 0;
  int    acc_cnt;
  logic  iv_q;
  exp_t  q[$];
  string ph_req = "R6";
  bit    gap_en = 1'b0;

  bit mf, mv, mh, pend_sol, pend_sof, last_f;
  int nidx;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid656_rx u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_valid  (pix_valid),
    .pix_data   (pix_data),
    .cfg_wide   (cfg_wide),
    .cfg_mode   (cfg_mode),
    .vid_valid  (vid_valid),
    .vid_data   (vid_data),
    .vid_sol    (vid_sol),
    .vid_sof    (vid_sof),
    .vid_field  (vid_field),
    .vid_vblank (vid_vblank),
    .vid_hblank (vid_hblank)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_cnt <= 0;
      iv_q    <= 1'b0;
    end else begin
      if (pix_valid) acc_cnt <= acc_cnt + 1;
      iv_q <= pix_valid;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as results come out
  always @(negedge clk) begin
    if (rst_n) begin
      if (!iv_q) check(!vid_valid, "R12", "output after idle cycle", vid_valid, 0);
      if (vid_valid) begin
        if (q.size() == 0) begin
          check(1'b0, ph_req, "unexpected word", vid_data, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(acc_cnt == e.idx + 5, "R4", "latency (accepted count)", acc_cnt, e.idx + 5);
          check(vid_data == e.d, ph_req, "data", vid_data, e.d);
          check({vid_field, vid_vblank, vid_hblank} == {e.f, e.v, e.h}, "R2 R9", "flags",
                {vid_field, vid_vblank, vid_hblank}, {e.f, e.v, e.h});
          check(vid_sol == e.sol, "R11", "start of line", vid_sol, e.sol);
          check(vid_sof == e.sof, "R10", "start of field", vid_sof, e.sof);
        end
      end
    end
  end

  function automatic logic [9:0] mk(input logic [7:0] key, input logic [1:0] ext);
    return cfg_wide ? {key, ext} : {ext, key};
  endfunction

  task automatic put(input logic [9:0] w, input bit trs, input bit is_sav);
    bit pass, chg;
    case (cfg_mode)
      2'd0:    pass = !trs && !mv && !mh;
      2'd1:    pass = !trs && mv;
      default: pass = 1'b1;
    endcase
    chg    = (mf != last_f);
    last_f = mf;
    if (pass) begin
      exp_t e;
      e.idx = nidx; e.d = w; e.f = mf; e.v = mv; e.h = mh;
      e.sol = pend_sol; e.sof = pend_sof | chg;
      q.push_back(e);
      pend_sol = 1'b0;
      pend_sof = 1'b0;
    end else begin
      pend_sof = pend_sof | chg;
    end
    if (is_sav) pend_sol = 1'b1;
    @(negedge clk);
    pix_valid = 1'b1;
    pix_data  = w;
    nidx++;
    if (gap_en && (nidx % 5 == 0)) begin
      @(negedge clk);
      pix_valid = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic send_trs(input bit f, input bit v, input bit h);
    logic [7:0] st;
    st = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    put(mk(8'hFF, 2'd3), 1'b1, 1'b0);
    put(mk(8'h00, 2'd1), 1'b1, 1'b0);
    put(mk(8'h00, 2'd2), 1'b1, 1'b0);
    mf = f; mv = v; mh = h;
    put(mk(st, 2'd0), 1'b1, !h);
  endtask

  task automatic send_samp(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) put(mk(base + 8'(i * 3), 2'(i)), 1'b0, 1'b0);
  endtask

  task automatic send_frame();
    send_trs(0, 1, 1); send_samp(3, 8'h20);
    send_trs(0, 1, 0); send_samp(4, 8'h30);
    for (int ln = 0; ln < 2; ln++) begin
      send_trs(0, 0, 1); send_samp(2, 8'h50);
      send_trs(0, 0, 0); send_samp(3, 8'h60);
      // near miss: marker bit clear, so it is ordinary video (R2)
      put(mk(8'hFF, 2'd0), 1'b0, 1'b0);
      put(mk(8'h00, 2'd0), 1'b0, 1'b0);
      put(mk(8'h00, 2'd0), 1'b0, 1'b0);
      put(mk(8'h40, 2'd0), 1'b0, 1'b0);
      send_samp(2, 8'h70);
    end
    send_trs(1, 1, 1); send_samp(2, 8'h90);
    send_trs(1, 1, 0); send_samp(3, 8'hA0);
    send_trs(1, 0, 0); send_samp(3, 8'hB0);
    send_trs(1, 0, 1); send_samp(4, 8'hC0);
  endtask

  task automatic run_phase(input logic [1:0] mode, input bit wide, input bit gap,
                           input string req);
    @(negedge clk);
    rst_n = 1'b0; pix_valid = 1'b0;
    cfg_mode = mode; cfg_wide = wide; gap_en = gap; ph_req = req;
    mf = 0; mv = 0; mh = 1; pend_sol = 0; pend_sof = 0; last_f = 0; nidx = 0;
    q.delete();
    repeat (2) @(negedge clk);
    // R1: reset state
    check({vid_valid, vid_sol, vid_sof} == 3'b000, "R1", "markers in reset",
          {vid_valid, vid_sol, vid_sof}, 0);
    check({vid_field, vid_vblank, vid_hblank} == 3'b001, "R1", "flags in reset",
          {vid_field, vid_vblank, vid_hblank}, 1);
    rst_n = 1'b1;
    send_frame();
    @(negedge clk);
    pix_valid = 1'b0;
    repeat (6) @(negedge clk);
    // words still held in the delay line are not due
    while (q.size() > 0 && q[q.size()-1].idx >= nidx - 4) void'(q.pop_back());
    check(q.size() == 0, "R4", "expected words not produced", q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    run_phase(2'd0, 1'b0, 1'b0, "R6");
    run_phase(2'd1, 1'b0, 1'b0, "R7");
    run_phase(2'd2, 1'b0, 1'b0, "R8");
    run_phase(2'd3, 1'b0, 1'b0, "R5");
    run_phase(2'd0, 1'b1, 1'b0, "R3");
    run_phase(2'd1, 1'b1, 1'b0, "R3");
    run_phase(2'd2, 1'b0, 1'b1, "R12");
    run_phase(2'd0, 1'b0, 1'b1, "R12");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule